// File: doc/BRIEF.md
# RTC Interrupt Flag and Enable Unit

This block holds the interrupt status and enable state of a PC-style real-time clock. Three event sources feed it one-cycle pulses: a periodic tick, an alarm match and an update-ended notice. Each source has a sticky flag in a status byte and an enable bit in a control byte. Both bytes use the same bit position for a given source, so one mask serves both. A flag records its event even while that source is disabled. The interrupt output and the master request bit, however, only reflect sources whose flag and enable are both set.

Software reaches the two bytes through a plain register port with one address bit. Reading the status byte returns the flags and clears them, so the next read shows nothing pending unless a new event has arrived. Writing the control byte changes only the enables. If a source is enabled while its flag is already set, the request rises straight away. The port carries no stream data, so it has no valid/ready handshake. Read data is combinational from the addressed register, and a read or write takes effect at the clock edge at which its strobe is high.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset all three flags, all three enables, the master request bit and `irq` are zero.
- R2: A one-cycle pulse on an event input sets its status flag at the next clock edge, whatever its enable. The status byte is at address 1, with periodic at bit 6, alarm at bit 5 and update at bit 4.
- R3: A write to address 0 loads the enables from bits 6 (periodic), 5 (alarm) and 4 (update) of the write data, and it leaves every flag unchanged.
- R4: Status bit 7 (master request) is 1 exactly when some flag and its matching enable are both 1, and `irq` always equals that bit.
- R5: Enabling a source whose flag is already set drives `irq` high in the cycle after the write edge.
- R6: A status read returns the flags as they stood before the read edge, and it clears all flags at that edge. A second read directly after it returns 0x00 if no event arrived in between.
- R7: An event pulse in the same cycle as a status read is not lost. The read returns the older value, and the new flag is set afterwards.
- R8: Reading the control byte clears nothing, and writes to the status address have no effect.
- R9: Bits 3 to 0 of both bytes, and bit 7 of the control byte, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_periodic | input | 1 | One-cycle periodic event pulse |
| evt_alarm | input | 1 | One-cycle alarm event pulse |
| evt_update | input | 1 | One-cycle update-ended event pulse |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a status read clears the flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed byte |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest case is an event that lands in the very cycle a status read clears the flags. Here the returned byte must still show the old value, and the new flag must remain set for the next read. The bench reaches this case by raising the event input and the read strobe on the same falling edge. It samples the read data before the rising edge, and then reads again. A second delicate case is a flag that was set while its source was disabled. The bench first shows that `irq` stays low and that bit 7 stays clear. Only then does it write the enable, and it checks that `irq` goes high one edge later.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NUM_SRC    = 3;
  localparam int DATA_W     = 8;
  localparam int FIELD_LSB  = 4;
  localparam int MASTER_BIT = 7;
  localparam int SRC_UPD    = 0;
  localparam int SRC_ALM    = 1;
  localparam int SRC_PER    = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr)    flags[i] <= 1'b0;
    end

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt[i]) |=> !flags[i]);
    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !evt[i]) |=> $stable(flags[i]));
  end
endmodule

// File: rtl/rtc_irq_enable_reg.sv
module rtc_irq_enable_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wfield,
  output logic [N-1:0] en
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en <= '0;
    else if (wr) en <= wfield;
  end

  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en));
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NUM_SRC-1:0] evt_vec, flags, en;
  logic               stat_clr, ctrl_wr, master;

  always_comb begin
    evt_vec          = '0;
    evt_vec[SRC_UPD] = evt_update;
    evt_vec[SRC_ALM] = evt_alarm;
    evt_vec[SRC_PER] = evt_periodic;
  end

  assign stat_clr = reg_rd && (reg_addr == ADDR_STAT);
  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);

  rtc_irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr(stat_clr), .flags(flags)
  );

  rtc_irq_enable_reg #(.N(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr),
    .wfield(reg_wdata[FIELD_LSB +: NUM_SRC]), .en(en)
  );

  assign master = |(flags & en);
  assign irq    = master;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STAT) begin
      reg_rdata[FIELD_LSB +: NUM_SRC] = flags;
      reg_rdata[MASTER_BIT]           = master;
    end else begin
      reg_rdata[FIELD_LSB +: NUM_SRC] = en;
    end
  end

  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|evt_vec) || $past(ctrl_wr)));
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(stat_clr) || $past(ctrl_wr)));
  assert_rd_before_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && evt_periodic) |=> reg_addr != ADDR_STAT || reg_rdata[FIELD_LSB + SRC_PER]);
endmodule

// File: tb/rtc_irq_unit_tb.sv
module rtc_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
  logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .evt_periodic(evt_periodic), .evt_alarm(evt_alarm),
    .evt_update(evt_update), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // events as mask {periodic, alarm, update} at bits 6,5,4
  task automatic pulse(logic [7:0] m);
    @(negedge clk);
    evt_periodic = m[6]; evt_alarm = m[5]; evt_update = m[4];
    @(negedge clk);
    evt_periodic = 0; evt_alarm = 0; evt_update = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic peek(logic a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    peek(1'b1, d); chk("R1 status", d, 8'h00);
    peek(1'b0, d); chk("R1 control", d, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_set_disabled;
    logic [7:0] d;
    pulse(8'h20);
    peek(1'b1, d); chk("R2 alarm flag while disabled", d, 8'h20);
    chk("R4 irq low when disabled", {7'd0, irq}, 8'h00);
    pulse(8'h50);
    peek(1'b1, d); chk("R2 all flags", d, 8'h70);
  endtask

  task automatic t_enable_pending;
    logic [7:0] d;
    wr(1'b0, 8'h20);
    chk("R5 irq after enable", {7'd0, irq}, 8'h01);
    peek(1'b1, d); chk("R3 flags kept and R4 master", d, 8'hF0);
    peek(1'b0, d); chk("R3 control readback", d, 8'h20);
  endtask

  task automatic t_read_clear;
    logic [7:0] d;
    rd(1'b1, d); chk("R6 first read", d, 8'hF0);
    chk("R6 irq cleared", {7'd0, irq}, 8'h00);
    rd(1'b1, d); chk("R6 second read empty", d, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] d;
    pulse(8'h10);
    @(negedge clk);
    reg_addr = 1; reg_rd = 1; evt_periodic = 1;
    #1 d = reg_rdata;
    chk("R7 read returns old", d, 8'h10);
    @(negedge clk);
    reg_rd = 0; evt_periodic = 0;
    rd(1'b1, d); chk("R7 new flag survives", d, 8'h40);
  endtask

  task automatic t_misc;
    logic [7:0] d;
    wr(1'b0, 8'hFF);
    peek(1'b0, d); chk("R9 control reserved zero", d, 8'h70);
    pulse(8'h40);
    chk("R4 irq periodic", {7'd0, irq}, 8'h01);
    rd(1'b0, d); chk("R8 control read", d, 8'h70);
    wr(1'b1, 8'h00);
    peek(1'b1, d); chk("R8 status intact", d, 8'hC0);
    wr(1'b0, 8'h00);
    chk("R4 irq drops on disable", {7'd0, irq}, 8'h00);
    peek(1'b1, d); chk("R3 flag kept after disable", d, 8'h40);
    wr(1'b0, 8'h10);
    pulse(8'h10);
    peek(1'b1, d); chk("R9 status low nibble zero", d, 8'hD0);
    chk("R4 irq update", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_set_disabled();
    t_enable_pending();
    t_read_clear();
    t_race();
    t_misc();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule